// File: doc/BRIEF.md
# Floating-Point Exception Signalling Controller

This controller sits beside a floating-point unit and follows the exception conditions reported by each arithmetic instruction as it completes. It keeps sticky status flags for scalar and for SIMD results, records whether an unmasked scalar exception is still waiting for its handler, and judges every instruction presented for issue: it may issue, it must freeze, or it must raise a native exception request.

Two reporting styles are supported. In legacy mode a pending scalar exception pulls an active-low error pin. The next waiting instruction then stalls until a handler clear strobe arrives, unless the ignore-error input is asserted. In native mode the pin stays quiet and the next waiting instruction raises an internal exception request. SIMD exceptions never use the pin, never freeze and do not depend on the ignore-error input. No-wait instructions pass straight through and open no interrupt sampling window.

Top module: `fpx_signal_ctrl`

## Requirements
- R1: A completing scalar instruction (`done_valid`=1, `done_simd`=0) ORs `done_flags` into `fpu_stat`, whatever the masks are. Flag bits: 0 arithmetic-invalid, 1 stack fault, 2 divide-by-zero, 3 denormal, 4 overflow, 5 underflow, 6 inexact. The flags hold until `hclr`.
- R2: A flag is unmasked when its mask bit is 0. Mask bits: 0 invalid (covers flag bits 0 and 1), 1 divide-by-zero, 2 denormal, 3 overflow, 4 underflow, 5 inexact. A completion whose flags are all masked creates no pending exception, so `err_n` stays 1 and no freeze follows.
- R3: An unmasked scalar exception makes the state pending from the next cycle. While it is pending, `native_mode`=0 and `ign_err`=0, `freeze` is 1 in the same cycle for an issuing class of 1 (waiting FPU op) or 3 (WAIT). It is 0 for class 0 (other) and class 4 (SIMD).
- R4: Class 2 (no-wait FPU op) never freezes, even while an exception is pending.
- R5: While `ign_err`=1, waiting classes issue without freezing. The pending state is kept, so freezing resumes as soon as `ign_err` returns to 0.
- R6: With `native_mode`=0, `err_n` goes to 0 one cycle after an unmasked scalar exception completes and stays there until `hclr`.
- R7: With `native_mode`=1, an unmasked scalar exception leaves `err_n` at 1. While it is pending, a waiting class (1 or 3) asserts `native_req` in the same cycle and does not freeze. Class 2 does not assert `native_req`.
- R8: A SIMD completion (`done_simd`=1) ORs its flags into `simd_stat` only, using `simd_mask` with the same bit layout as R2. It asserts `native_req` in the same cycle when any flag is unmasked. It never changes `err_n` or `freeze`, whatever the values of `ign_err` and `native_mode`.
- R9: `irq_ack` equals `ext_irq` AND `int_en`, and is forced to 0 while a class 2 instruction issues.
- R10: `hclr` clears the pending state, `fpu_stat` and the error pin from the next cycle, which releases any freeze. It wins over a scalar completion in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_valid | input | 1 | An instruction completes this cycle |
| done_simd | input | 1 | The completing instruction is SIMD class |
| done_flags | input | 7 | Exception flags of the completing instruction |
| fpu_mask | input | 6 | Scalar exception masks (1 = masked) |
| simd_mask | input | 6 | SIMD exception masks (1 = masked) |
| issue_valid | input | 1 | An instruction is presented for issue |
| issue_class | input | 3 | 0 other, 1 waiting FPU, 2 no-wait FPU, 3 WAIT, 4 SIMD |
| ign_err | input | 1 | Ignore-error input, active high |
| native_mode | input | 1 | 1 = native exception reporting |
| int_en | input | 1 | Interrupt-enable flag |
| ext_irq | input | 1 | External interrupt request |
| hclr | input | 1 | Handler clear strobe |
| err_n | output | 1 | Active-low error pin |
| freeze | output | 1 | Stall the presented instruction |
| native_req | output | 1 | Internal exception request |
| irq_ack | output | 1 | Interrupt request accepted |
| fpu_stat | output | 7 | Sticky scalar flags |
| simd_stat | output | 7 | Sticky SIMD flags |

## Verification
The block has no parameters, so the bench builds it in its one configuration, and that configuration reaches every class code and every mode combination. The directed scenarios cover fully masked and unmasked completions, both reporting modes, ignore-error toggling during a pending exception, SIMD exceptions while the ignore-error input changes, and a clear that coincides with a new completion.

// File: rtl/fpx_signal_ctrl.sv
module fpx_signal_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done_valid,
  input  logic       done_simd,
  input  logic [6:0] done_flags,
  input  logic [5:0] fpu_mask,
  input  logic [5:0] simd_mask,
  input  logic       issue_valid,
  input  logic [2:0] issue_class,
  input  logic       ign_err,
  input  logic       native_mode,
  input  logic       int_en,
  input  logic       ext_irq,
  input  logic       hclr,
  output logic       err_n,
  output logic       freeze,
  output logic       native_req,
  output logic       irq_ack,
  output logic [6:0] fpu_stat,
  output logic [6:0] simd_stat
);
  localparam logic [2:0] CLS_FWAIT   = 3'd1;
  localparam logic [2:0] CLS_FNOWAIT = 3'd2;
  localparam logic [2:0] CLS_WAIT    = 3'd3;

  logic [6:0] fmask7, smask7;
  logic       fpu_done, simd_done, fpu_hit, simd_hit;
  logic       waiting, nowait;
  logic       pend_q, err_q;

  assign fmask7    = {fpu_mask[5:1], fpu_mask[0], fpu_mask[0]};
  assign smask7    = {simd_mask[5:1], simd_mask[0], simd_mask[0]};
  assign fpu_done  = done_valid & ~done_simd;
  assign simd_done = done_valid & done_simd;
  assign fpu_hit   = fpu_done & |(done_flags & ~fmask7);
  assign simd_hit  = simd_done & |(done_flags & ~smask7);

  assign waiting = issue_valid & ((issue_class == CLS_FWAIT) | (issue_class == CLS_WAIT));
  assign nowait  = issue_valid & (issue_class == CLS_FNOWAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
      fpu_stat <= '0;
    end else if (hclr) begin
      pend_q   <= 1'b0;
      err_q    <= 1'b0;
      fpu_stat <= '0;
    end else begin
      if (fpu_done) fpu_stat <= fpu_stat | done_flags;
      if (fpu_hit) pend_q <= 1'b1;
      if (fpu_hit && !native_mode) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) simd_stat <= '0;
    else if (simd_done) simd_stat <= simd_stat | done_flags;
  end

  assign err_n      = ~err_q;
  assign freeze     = waiting & pend_q & ~native_mode & ~ign_err;
  assign native_req = (waiting & pend_q & native_mode) | simd_hit;
  assign irq_ack    = ext_irq & int_en & ~nowait;
endmodule

// File: rtl/fpx_signal_ctrl_chk.sv
module fpx_signal_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done_valid,
  input logic       done_simd,
  input logic       native_mode,
  input logic       issue_valid,
  input logic [2:0] issue_class,
  input logic       ign_err,
  input logic       int_en,
  input logic       ext_irq,
  input logic       hclr,
  input logic       err_n,
  input logic       freeze,
  input logic       irq_ack
);
  p_nowait_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_class == 3'd2) |-> !freeze);

  p_ignore_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ign_err |-> !freeze);

  p_pin_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err_n) |-> $past(done_valid && !done_simd && !native_mode && !hclr));

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (int_en && ext_irq));

  p_clear_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hclr |=> (err_n && !freeze));
endmodule

bind fpx_signal_ctrl fpx_signal_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .done_valid(done_valid), .done_simd(done_simd),
  .native_mode(native_mode), .issue_valid(issue_valid), .issue_class(issue_class),
  .ign_err(ign_err), .int_en(int_en), .ext_irq(ext_irq), .hclr(hclr),
  .err_n(err_n), .freeze(freeze), .irq_ack(irq_ack)
);

// File: tb/fpx_signal_ctrl_test.sv
module fpx_signal_ctrl_test;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic done_valid = 0, done_simd = 0;
  logic [6:0] done_flags = '0;
  logic [5:0] fpu_mask = '1, simd_mask = '1;
  logic issue_valid = 0;
  logic [2:0] issue_class = '0;
  logic ign_err = 0, native_mode = 0, int_en = 0, ext_irq = 0, hclr = 0;
  logic err_n, freeze, native_req, irq_ack;
  logic [6:0] fpu_stat, simd_stat;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpx_signal_ctrl uut (
    .clk(clk), .rst_n(rst_n), .done_valid(done_valid), .done_simd(done_simd),
    .done_flags(done_flags), .fpu_mask(fpu_mask), .simd_mask(simd_mask),
    .issue_valid(issue_valid), .issue_class(issue_class), .ign_err(ign_err),
    .native_mode(native_mode), .int_en(int_en), .ext_irq(ext_irq), .hclr(hclr),
    .err_n(err_n), .freeze(freeze), .native_req(native_req), .irq_ack(irq_ack),
    .fpu_stat(fpu_stat), .simd_stat(simd_stat)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic complete(logic simd, logic [6:0] f);
    @(negedge clk);
    done_valid = 1; done_simd = simd; done_flags = f;
    @(negedge clk);
    done_valid = 0; done_simd = 0; done_flags = '0;
    #1;
  endtask

  task automatic present(logic [2:0] c);
    issue_valid = 1; issue_class = c; #1;
  endtask

  task automatic clear();
    @(negedge clk); hclr = 1;
    @(negedge clk); hclr = 0; issue_valid = 0; #1;
  endtask

  task automatic t_reset();
    present(3'd1);
    chk("R6 reset err_n", err_n, 1);
    chk("R3 reset freeze", freeze, 0);
    chk("R1 reset fpu_stat", fpu_stat, 0);
    chk("R8 reset simd_stat", simd_stat, 0);
    issue_valid = 0;
  endtask

  task automatic t_masked();
    fpu_mask = '1;
    complete(0, 7'h12);
    chk("R1 masked flags recorded", fpu_stat, 7'h12);
    chk("R2 masked no pin", err_n, 1);
    present(3'd3);
    chk("R2 masked no freeze", freeze, 0);
    issue_valid = 0;
    fpu_mask = 6'b111110;
    complete(0, 7'h02);
    present(3'd1);
    chk("R2 stack fault unmasked via invalid mask", freeze, 1);
    clear();
    fpu_mask = '1;
  endtask

  task automatic t_legacy();
    fpu_mask = '0; native_mode = 0;
    complete(0, 7'h04);
    chk("R6 pin low", err_n, 0);
    chk("R1 stat", fpu_stat, 7'h04);
    present(3'd1); chk("R3 fpu wait freeze", freeze, 1);
    present(3'd3); chk("R3 WAIT freeze", freeze, 1);
    present(3'd0); chk("R3 other no freeze", freeze, 0);
    present(3'd4); chk("R3 simd no freeze", freeze, 0);
    present(3'd2); chk("R4 nowait no freeze", freeze, 0);
    ext_irq = 1; int_en = 0; present(3'd1);
    chk("R9 disabled no ack", irq_ack, 0);
    int_en = 1; present(3'd2);
    chk("R9 nowait no ack", irq_ack, 0);
    present(3'd1);
    chk("R9 ack", irq_ack, 1);
    ext_irq = 0; int_en = 0;
    settle();
    chk("R6 pin held", err_n, 0);
    chk("R3 freeze held", freeze, 1);
  endtask

  task automatic t_ignore();
    present(3'd1);
    ign_err = 1; #1;
    chk("R5 ignore no freeze", freeze, 0);
    settle();
    ign_err = 0; #1;
    chk("R5 pending kept", freeze, 1);
  endtask

  task automatic t_clear();
    clear();
    chk("R10 pin released", err_n, 1);
    chk("R10 stat cleared", fpu_stat, 0);
    present(3'd1);
    chk("R10 freeze released", freeze, 0);
    issue_valid = 0;
    @(negedge clk);
    done_valid = 1; done_flags = 7'h10; hclr = 1;
    @(negedge clk);
    done_valid = 0; done_flags = '0; hclr = 0; #1;
    chk("R10 clear beats completion pin", err_n, 1);
    chk("R10 clear beats completion stat", fpu_stat, 0);
    present(3'd3);
    chk("R10 clear beats completion freeze", freeze, 0);
    issue_valid = 0;
  endtask

  task automatic t_native();
    native_mode = 1; fpu_mask = '0;
    complete(0, 7'h01);
    chk("R7 no pin", err_n, 1);
    present(3'd1);
    chk("R7 request", native_req, 1);
    chk("R7 no freeze", freeze, 0);
    present(3'd2);
    chk("R7 nowait no request", native_req, 0);
    clear();
    native_mode = 0;
  endtask

  task automatic t_simd();
    simd_mask = '0; fpu_mask = '0;
    @(negedge clk);
    done_valid = 1; done_simd = 1; done_flags = 7'h40; ign_err = 1; #1;
    chk("R8 simd request", native_req, 1);
    @(negedge clk);
    done_valid = 0; done_simd = 0; done_flags = '0; ign_err = 0; #1;
    chk("R8 simd no pin", err_n, 1);
    chk("R8 simd stat", simd_stat, 7'h40);
    chk("R1 simd leaves fpu_stat", fpu_stat, 0);
    present(3'd4);
    chk("R8 simd issue no freeze", freeze, 0);
    present(3'd1);
    chk("R8 no scalar pending", freeze, 0);
    issue_valid = 0;
    settle();
    chk("R8 pin still high", err_n, 1);
    simd_mask = '1;
    @(negedge clk);
    done_valid = 1; done_simd = 1; done_flags = 7'h08; #1;
    chk("R8 masked simd no request", native_req, 0);
    @(negedge clk);
    done_valid = 0; done_simd = 0; done_flags = '0; #1;
    chk("R8 simd sticky", simd_stat, 7'h48);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    settle();
    t_reset();
    t_masked();
    t_legacy();
    t_ignore();
    t_clear();
    t_native();
    t_simd();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule